// File: doc/BRIEF.md
# Four-Pin Serial I/O Expander

This block is a two-wire serial bus target (I2C) that lets a bus master control four general-purpose pins. Four 4-bit registers sit behind a register pointer: a captured copy of the pin inputs, the latched output values, a per-bit read inversion mask, and a per-pin direction mask. The direction mask resets with every pin as an input, so nothing is driven until the master asks for it.

A write transaction is the address with the write bit, then a command byte whose low two bits load the pointer, then one or more data bytes whose low nibble goes into the selected register. A read transaction returns the register that the last command byte selected. The bus lines are oversampled by the system clock through synchronizers. The open-drain data line is modelled as a pull-down enable. The pin inputs pass through a two-stage synchronizer before they are captured.

Top module: `quad_pin_expander`

## Requirements
- R1: After reset the output register is 4'hF, the inversion mask is 4'h0, the direction mask is 4'hF, the pointer is 0, no pin is driven, and SDA is released.
- R2: `pin_oe[i]` is high exactly when direction bit i is 0 (1 = input). `pin_out` carries the output register.
- R3: The target acknowledges an address byte whose upper seven bits equal `DEV_ADDR` (default 7'h41) by pulling SDA low for the ninth clock. On any other address it does not acknowledge, and it ignores the bus until the next START or STOP.
- R4: In a write, the command byte's bits [1:0] load the pointer (0 input, 1 output, 2 inversion, 3 direction). Each following data byte is acknowledged, and its bits [3:0] are loaded into the selected register.
- R5: A data byte written while the pointer is 0 changes no register.
- R6: A read byte carries the selected register in bits [3:0], with bits [7:4] zero. While the master acknowledges, further bytes repeat the same register.
- R7: Reading pointer 0 returns the synchronized pins captured at the acknowledge of the read address, XOR the inversion mask. Pin changes after that capture do not affect the transaction.
- R8: A START or STOP in the middle of a byte discards that byte. A STOP returns the target to idle, and a START begins a new address phase.
- R9: The target changes its SDA drive only while the synchronized SCL is low.
- R10: A reset applied in the middle of a transaction returns the bus logic to idle and all registers to their defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pin_in | input | 4 | Pin input levels |
| pin_out | output | 4 | Output register value toward the pins |
| pin_oe | output | 4 | Per-pin drive enable |

## Verification
Register traffic is tried with distinct nibbles in each register (5, C, 6, A, 2), so that a wrong pointer decode, a wrong nibble, or leakage into the upper bits yields a different byte. The input path is read with several pin and mask combinations (9 with 6, 3 with 6, 0 with 6). It is also read with pins that change after the address acknowledge, which separates capture at the address from live sampling. Foreign addresses, partial bytes cut by STOP or START, multi-byte reads and writes, and a reset in mid-byte show whether the bus logic discards or keeps what it should.

// File: rtl/qpe_pkg.sv
package qpe_pkg;

    localparam int NPIN  = 4;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_CFG = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_CMD,
        BS_WDATA,
        BS_ACK,
        BS_RDATA,
        BS_RACK,
        BS_SKIP
    } bus_state_e;

    typedef struct packed {
        logic [NPIN-1:0] in_cap;
        logic [NPIN-1:0] out_lat;
        logic [NPIN-1:0] inv_mask;
        logic [NPIN-1:0] dir_mask;
    } regbank_t;

    localparam logic [NPIN-1:0] OUT_RST = '1;
    localparam logic [NPIN-1:0] INV_RST = '0;
    localparam logic [NPIN-1:0] DIR_RST = '1;

    function automatic logic [7:0] pick_reg(input sel_e sel, input regbank_t rb);
        logic [NPIN-1:0] v;
        case (sel)
            SEL_IN:  v = rb.in_cap ^ rb.inv_mask;
            SEL_OUT: v = rb.out_lat;
            SEL_POL: v = rb.inv_mask;
            default: v = rb.dir_mask;
        endcase
        return {{(8-NPIN){1'b0}}, v};
    endfunction

endpackage

// File: rtl/qpe_sync.sv
module qpe_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= {W{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qpe_bus_target.sv
module qpe_bus_target
    import qpe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h41
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic [7:0] tx_byte,
    output logic       sda_oe,
    output logic       cmd_stb,
    output logic       data_stb,
    output logic       cap_stb,
    output logic [3:0] rx_nib
);
    logic       scl_q, sda_q;
    logic       scl_rise, scl_fall, start_det, stop_det;
    bus_state_e st, st_after;
    logic [3:0] bit_cnt;
    logic [7:0] shreg, txreg;
    logic       mack;

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    assign rx_nib    = shreg[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            st       <= BS_IDLE;
            st_after <= BS_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            txreg    <= '0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            cmd_stb  <= 1'b0;
            data_stb <= 1'b0;
            cap_stb  <= 1'b0;
        end else begin
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            cmd_stb  <= 1'b0;
            data_stb <= 1'b0;
            cap_stb  <= 1'b0;
            if (start_det) begin
                st      <= BS_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                st      <= BS_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (st)
                    BS_ADDR, BS_CMD, BS_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (st == BS_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe <= 1'b1;
                                    st     <= BS_ACK;
                                    if (shreg[0]) begin
                                        st_after <= BS_RDATA;
                                        cap_stb  <= 1'b1;
                                    end else begin
                                        st_after <= BS_CMD;
                                    end
                                end else begin
                                    st <= BS_SKIP;
                                end
                            end else if (st == BS_CMD) begin
                                sda_oe   <= 1'b1;
                                cmd_stb  <= 1'b1;
                                st       <= BS_ACK;
                                st_after <= BS_WDATA;
                            end else begin
                                sda_oe   <= 1'b1;
                                data_stb <= 1'b1;
                                st       <= BS_ACK;
                                st_after <= BS_WDATA;
                            end
                        end
                    end
                    BS_ACK: begin
                        if (scl_fall) begin
                            st <= st_after;
                            if (st_after == BS_RDATA) begin
                                txreg   <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                                bit_cnt <= '0;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    BS_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                mack    <= 1'b0;
                                bit_cnt <= '0;
                                st      <= BS_RACK;
                            end else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                sda_oe <= ~txreg[6];
                            end
                        end
                    end
                    BS_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                txreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                st     <= BS_RDATA;
                            end else begin
                                st <= BS_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: drive on SDA only moves while SCL is seen low
    a_r9_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (rst)
        scl_s |=> $stable(sda_oe));

    // R3: a foreign address is never acknowledged
    a_r3_no_ack_foreign: assert property (@(posedge clk) disable iff (rst)
        (st == BS_ADDR && scl_fall && bit_cnt == 4'd8 && shreg[7:1] != DEV_ADDR)
        |=> (!sda_oe && st == BS_SKIP));

    // R1: released data line whenever idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == BS_IDLE) |-> !sda_oe);

    // R8: a STOP always lands in idle with the line released
    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (st == BS_IDLE && !sda_oe));
endmodule

// File: rtl/qpe_regs.sv
module qpe_regs
    import qpe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pins_s,
    input  logic            cap_stb,
    input  logic            cmd_stb,
    input  logic            data_stb,
    input  logic [3:0]      rx_nib,
    output logic [7:0]      tx_byte,
    output logic [NPIN-1:0] out_q,
    output logic [NPIN-1:0] dir_q
);
    regbank_t rb;
    sel_e     ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb.in_cap   <= '0;
            rb.out_lat  <= OUT_RST;
            rb.inv_mask <= INV_RST;
            rb.dir_mask <= DIR_RST;
            ptr         <= SEL_IN;
        end else begin
            if (cap_stb) rb.in_cap <= pins_s;
            if (cmd_stb) ptr <= sel_e'(rx_nib[SEL_W-1:0]);
            if (data_stb) begin
                case (ptr)
                    SEL_OUT: rb.out_lat  <= rx_nib[NPIN-1:0];
                    SEL_POL: rb.inv_mask <= rx_nib[NPIN-1:0];
                    SEL_CFG: rb.dir_mask <= rx_nib[NPIN-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign tx_byte = pick_reg(ptr, rb);
    assign out_q   = rb.out_lat;
    assign dir_q   = rb.dir_mask;

    // R1: defaults one cycle after reset
    a_r1_reset_defaults: assert property (@(posedge clk)
        rst |=> (rb.out_lat == OUT_RST && rb.inv_mask == INV_RST &&
                 rb.dir_mask == DIR_RST && ptr == SEL_IN));

    // R5: data aimed at the input register leaves it alone
    a_r5_input_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (data_stb && ptr == SEL_IN && !cap_stb) |=> $stable(rb.in_cap));

    // R7: capture takes the synchronized pins of the strobe cycle
    a_r7_capture_value: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> (rb.in_cap == $past(pins_s)));
endmodule

// File: rtl/quad_pin_expander.sv
module quad_pin_expander
    import qpe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h41,
    parameter int         SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    logic [1:0]      bus_s;
    logic [NPIN-1:0] pins_s;
    logic            cmd_stb, data_stb, cap_stb;
    logic [3:0]      rx_nib;
    logic [7:0]      tx_byte;
    logic [NPIN-1:0] out_q, dir_q;

    qpe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
    );

    qpe_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pins_s)
    );

    qpe_bus_target #(.DEV_ADDR(DEV_ADDR)) u_target (
        .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
        .tx_byte(tx_byte), .sda_oe(sda_oe), .cmd_stb(cmd_stb),
        .data_stb(data_stb), .cap_stb(cap_stb), .rx_nib(rx_nib)
    );

    qpe_regs u_regs (
        .clk(clk), .rst(rst), .pins_s(pins_s), .cap_stb(cap_stb),
        .cmd_stb(cmd_stb), .data_stb(data_stb), .rx_nib(rx_nib),
        .tx_byte(tx_byte), .out_q(out_q), .dir_q(dir_q)
    );

    assign pin_oe  = ~dir_q;
    assign pin_out = out_q;

    // R10: reset at any point leaves pins undriven and SDA released
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_oe && pin_oe == '0));
endmodule

// File: tb/tb_quad_pin_expander.sv
module tb_quad_pin_expander;
    localparam int Q = 20;
    localparam logic [6:0] ADDR = 7'h41;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] pin_in = 4'h0;
    logic       sda_oe;
    logic [3:0] pin_out, pin_oe;
    logic       sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    int sda_viol = 0;
    logic prev_oe = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    quad_pin_expander dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl_m) sda_viol++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(4); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(4); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tick(4); sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        tick(4); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2);
        acked = ~sda_bus; tick(Q/2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(4); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2);
            b[i] = sda_bus; tick(Q/2); scl_m = 1'b0;
        end
        tick(4); sda_m = ~ack; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
        tick(4); sda_m = 1'b1;
    endtask

    task automatic write_reg(input logic [1:0] p, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk("R3 write address ack", a, 1'b1);
        send_byte({6'h0, p}, a);   chk("R4 command ack", a, 1'b1);
        send_byte(d, a);           chk("R4 data ack", a, 1'b1);
        bus_stop();
    endtask

    task automatic set_ptr(input logic [1:0] p);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte({6'h0, p}, a);
        bus_stop();
    endtask

    task automatic read_cur(output logic [7:0] d);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk("R3 read address ack", a, 1'b1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic read_reg(input logic [1:0] p, output logic [7:0] d);
        set_ptr(p);
        read_cur(d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 sda released", sda_oe, 1'b0);
        chk("R1 pins undriven", pin_oe, 4'h0);
        chk("R1 output default", pin_out, 4'hF);
        read_reg(2'd1, d); chk("R1 output reg read", d, 8'h0F);
        read_reg(2'd2, d); chk("R1 inversion reg read", d, 8'h00);
        read_reg(2'd3, d); chk("R1 direction reg read", d, 8'h0F);
    endtask

    task automatic t_direction();
        logic [7:0] d;
        write_reg(2'd3, 8'hA5);
        chk("R2 oe from direction", pin_oe, 4'hA);
        read_reg(2'd3, d); chk("R6 direction readback", d, 8'h05);
        write_reg(2'd1, 8'h3C);
        chk("R2 pin_out from output reg", pin_out, 4'hC);
        read_reg(2'd1, d); chk("R6 output readback upper zero", d, 8'h0C);
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        write_reg(2'd2, 8'hF6);
        read_reg(2'd2, d); chk("R6 inversion readback", d, 8'h06);
        pin_in = 4'h9; tick(10);
        read_reg(2'd0, d); chk("R7 input 9 xor 6", d, 8'h0F);
        pin_in = 4'h3; tick(10);
        read_cur(d); chk("R7 input 3 xor 6", d, 8'h05);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        logic a;
        pin_in = 4'h9; tick(10);
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk("R3 read ack", a, 1'b1);
        pin_in = 4'h0;
        recv_byte(1'b1, d); chk("R7 capture held byte 1", d, 8'h0F);
        recv_byte(1'b0, d); chk("R6 R7 repeated byte", d, 8'h0F);
        bus_stop();
        read_cur(d); chk("R7 new capture", d, 8'h06);
    endtask

    task automatic t_in_write();
        logic [7:0] d;
        write_reg(2'd0, 8'h0A);
        read_reg(2'd1, d); chk("R5 output unchanged", d, 8'h0C);
        read_reg(2'd2, d); chk("R5 inversion unchanged", d, 8'h06);
        read_reg(2'd3, d); chk("R5 direction unchanged", d, 8'h05);
        read_reg(2'd0, d); chk("R5 input still pins xor mask", d, 8'h06);
    endtask

    task automatic t_bad_addr();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({7'h22, 1'b0}, a); chk("R3 foreign address nack", a, 1'b0);
        send_byte(8'h01, a);         chk("R3 ignored byte nack", a, 1'b0);
        send_byte(8'h00, a);         chk("R3 ignored data nack", a, 1'b0);
        bus_stop();
        chk("R3 output untouched", pin_out, 4'hC);
        bus_start();
        send_byte({7'h40, 1'b1}, a); chk("R3 foreign read nack", a, 1'b0);
        recv_byte(1'b0, d);          chk("R3 line not driven", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_multi_write();
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h01, a);
        send_byte(8'h01, a); chk("R4 first data ack", a, 1'b1);
        send_byte(8'h02, a); chk("R4 second data ack", a, 1'b1);
        bus_stop();
        chk("R4 last data kept", pin_out, 4'h2);
    endtask

    task automatic t_abort();
        logic a;
        write_reg(2'd1, 8'h05);
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h01, a);
        send_bits(8'hA0, 3);
        bus_stop();
        chk("R8 stop mid-byte discards", pin_out, 4'h5);
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h01, a);
        send_bits(8'hFF, 5);
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk("R8 restart address ack", a, 1'b1);
        send_byte(8'h01, a);
        send_byte(8'h0A, a);
        bus_stop();
        chk("R8 restart write lands", pin_out, 4'hA);
    endtask

    task automatic t_reset_mid();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h03, a);
        send_bits(8'h00, 4);
        rst = 1'b1; tick(4); rst = 1'b0; tick(2);
        chk("R10 sda released", sda_oe, 1'b0);
        chk("R10 pins undriven", pin_oe, 4'h0);
        chk("R10 output default", pin_out, 4'hF);
        bus_stop();
        pin_in = 4'h3; tick(10);
        read_cur(d); chk("R10 pointer back to input, mask clear", d, 8'h03);
    endtask

    initial begin
        rst = 1'b1; tick(5); rst = 1'b0; tick(5);
        t_reset();
        t_direction();
        t_polarity();
        t_capture();
        t_in_write();
        t_bad_addr();
        t_multi_write();
        t_abort();
        t_reset_mid();
        chk("R9 sda changes with scl high", sda_viol[7:0], 8'h00);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule